// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

This block turns queued packet bytes into a bit-serial HDLC line stream. Bytes enter through a write port into a small internal queue, each tagged with an end-of-packet marker. When a packet is ready, the framer sends an opening flag, then the payload with zero-bit insertion, then a 16-bit frame check sequence, then a closing flag. Between packets it fills the line with flags or all-ones idle bytes. An external strobe sets the pace: the framer moves one line bit on each clock cycle in which the strobe is high.

Five level controls change the output at run time. They can drop the check sequence, complement it, switch off bit stuffing, choose the fill pattern and complement the whole line stream. A flush control acts on its rising edge. It empties the queue, sends one abort byte and returns to fill. The framer also aborts a packet whose queue runs dry before its final byte and reports this with a pulse. Writes that arrive while the queue is full are dropped and reported.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset the queue is empty and not full, `underrun` and `overflow` are low, and the first eight line bits are a 7Eh flag sent least-significant bit first (0,1,1,1,1,1,1,0).
- R2: Between packets the line carries repeated 7Eh flags while `ctl_fill_idle` is 0 and repeated FFh bytes while it is 1. A change takes effect at the next byte boundary.
- R3: A packet is sent as a 7Eh flag, then the payload bytes least-significant bit first, then the 16-bit check sequence, then a 7Eh flag. The check sequence uses polynomial x^16+x^12+x^5+1 in bit-reversed form, with the register preset to FFFFh and updated over the payload bits. It is the ones-complement of the final register, sent as bits 0 through 15 in that order.
- R4: While `ctl_crc_inv` is 1 and `ctl_crc_off` is 0, all 16 check bits are sent complemented compared with R3, which means the raw register value is sent.
- R5: While `ctl_crc_off` is 1, no check sequence is sent and the closing flag follows the payload. `ctl_crc_inv` then has no effect on the line.
- R6: While `ctl_stuff_off` is 0, a 0 is inserted after every run of five consecutive 1s among the payload and check bits, including a run that ends on the last bit before the closing flag or an abort. Flags, fill and abort bytes are never stuffed.
- R7: While `ctl_stuff_off` is 1, no bits are inserted.
- R8: Each cycle with `bit_en` high moves exactly one line bit to `tx_bit`, one clock later. Inserted stuff bits take strobes of their own. `tx_bit` holds its value while `bit_en` is low. While `ctl_line_inv` is 1, every outgoing bit, flags, fill, abort and check bits included, is complemented.
- R9: A 0-to-1 transition of `ctl_flush` empties the queue by the next cycle, drops any write in that cycle, and makes the next line bits one FEh abort byte followed by fill.
- R10: A packet starts only when the queue holds at least two bytes, or holds one byte that carries the end-of-packet marker.
- R11: If the queue is empty when the next payload byte is needed and the end-of-packet byte has not yet been sent, the framer sends FEh (after any pending stuff bit), pulses `underrun` high for one cycle and returns to fill.
- R12: The queue holds 16 entries. `fifo_full` is high when 16 bytes are queued. A write while full is dropped, and `overflow` pulses high for one cycle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks the byte as the last of its packet |
| fifo_full | output | 1 | Queue holds its full depth |
| fifo_empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | One-cycle pulse: a write was dropped |
| ctl_crc_off | input | 1 | 1 omits the check sequence |
| ctl_crc_inv | input | 1 | 1 complements the check sequence |
| ctl_stuff_off | input | 1 | 1 disables zero-bit insertion |
| ctl_fill_idle | input | 1 | Fill select: 0 flags, 1 FFh |
| ctl_line_inv | input | 1 | 1 complements the line stream |
| ctl_flush | input | 1 | Rising edge flushes the queue and aborts |
| bit_en | input | 1 | Line bit strobe |
| tx_bit | output | 1 | Serial line bit |
| underrun | output | 1 | One-cycle pulse: packet aborted for lack of data |

## Verification
The bench builds the framer with its default depth of 16 entries. This lets it fill the queue in sixteen writes while the strobe is held low, so the full flag, a dropped seventeenth write and a flush from a full queue can all be reached directly. Packets of up to twelve bytes fit in the queue without stalling, so aborts come only from the deliberate underrun case. The random strobe density, between 40 and 100 percent, places stuff bits and byte boundaries on many different clock alignments.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int          BYTE_W       = 8;
    localparam int          FCS_W        = 16;
    localparam int          STUFF_RUN    = 5;
    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [7:0]  IDLE_BYTE    = 8'hFF;
    localparam logic [7:0]  ABORT_BYTE   = 8'hFE;
    localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_REV = 16'h8408;

    typedef struct packed {
        logic             last;
        logic [BYTE_W-1:0] data;
    } q_word_t;

    typedef struct packed {
        logic crc_off;
        logic crc_inv;
        logic stuff_off;
        logic fill_idle;
        logic line_inv;
    } tx_ctrl_t;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE,
        ST_ABORT
    } tx_state_t;

    // one bit of the bit-reversed CCITT check register
    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? FCS_POLY_REV : '0);
    endfunction

    // states whose bits sit between the flags and count toward stuffing
    function automatic logic is_body(input tx_state_t s);
        return (s == ST_DATA) || (s == ST_FCS_LO) || (s == ST_FCS_HI);
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          overflow
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    assign count   = wp - rp;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full && !flush;
    assign rd_ok   = rd_en && !empty && !flush;
    assign rd_data = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            overflow <= 1'b0;
        end else if (flush) begin
            wp       <= '0;
            rp       <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_en && full;
            if (wr_ok) wp <= wp + CW'(1);
            if (rd_ok) rp <= rp + CW'(1);
        end
    end

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             en,
    input  logic             bit_in,
    output logic [FCS_W-1:0] fcs_nx
);

    logic [FCS_W-1:0] fcs_q;

    assign fcs_nx = fcs_step(fcs_q, bit_in);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            fcs_q <= FCS_PRESET;
        end else if (en) begin
            fcs_q <= fcs_nx;
        end
    end

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             flush_evt,
    input  tx_ctrl_t         ctrl,
    input  q_word_t          head,
    input  logic [CW-1:0]    fifo_count,
    input  logic [FCS_W-1:0] fcs_nx,
    output logic             pop,
    output logic             fcs_init,
    output logic             fcs_en,
    output logic             fcs_bit,
    output logic             tx_bit,
    output logic             underrun
);

    tx_state_t   state, state_n;
    logic [7:0]  sh, sh_n, fcs_hi, fcs_hi_n;
    logic [2:0]  bitcnt, ones, ones_n;
    logic        cur_last, cur_last_n, urun_n;
    logic        stuff_now, shift_now, byte_end, have_byte, can_start, raw_bit;
    logic [FCS_W-1:0] fcs_out;

    always_comb begin
        stuff_now = bit_en && !ctrl.stuff_off && (ones == 3'(STUFF_RUN));
        shift_now = bit_en && !stuff_now;
        byte_end  = shift_now && (bitcnt == 3'd7);
        raw_bit   = stuff_now ? 1'b0 : sh[0];
        have_byte = (fifo_count != '0);
        can_start = (fifo_count >= CW'(2)) || (have_byte && head.last);
        fcs_en    = shift_now && (state == ST_DATA);
        fcs_bit   = sh[0];
        fcs_out   = ctrl.crc_inv ? fcs_nx : ~fcs_nx;
        if (is_body(state) && sh[0]) begin
            ones_n = (ones == 3'd7) ? ones : ones + 3'd1;
        end else begin
            ones_n = '0;
        end
    end

    // decision taken when the last bit of the current byte leaves
    always_comb begin
        state_n    = state;
        sh_n       = {1'b0, sh[7:1]};
        fcs_hi_n   = fcs_hi;
        cur_last_n = cur_last;
        pop        = 1'b0;
        fcs_init   = 1'b0;
        urun_n     = 1'b0;
        if (byte_end) begin
            unique case (state)
                ST_OPEN, ST_DATA: begin
                    if (state == ST_DATA && cur_last) begin
                        if (ctrl.crc_off) begin
                            state_n = ST_CLOSE;
                            sh_n    = FLAG_BYTE;
                        end else begin
                            state_n  = ST_FCS_LO;
                            sh_n     = fcs_out[7:0];
                            fcs_hi_n = fcs_out[15:8];
                        end
                    end else if (have_byte) begin
                        pop        = 1'b1;
                        state_n    = ST_DATA;
                        sh_n       = head.data;
                        cur_last_n = head.last;
                    end else begin
                        urun_n  = 1'b1;
                        state_n = ST_ABORT;
                        sh_n    = ABORT_BYTE;
                    end
                end
                ST_FCS_LO: begin
                    state_n = ST_FCS_HI;
                    sh_n    = fcs_hi;
                end
                ST_FCS_HI: begin
                    state_n = ST_CLOSE;
                    sh_n    = FLAG_BYTE;
                end
                default: begin
                    if (can_start) begin
                        state_n  = ST_OPEN;
                        sh_n     = FLAG_BYTE;
                        fcs_init = 1'b1;
                    end else begin
                        state_n = ST_FILL;
                        sh_n    = ctrl.fill_idle ? IDLE_BYTE : FLAG_BYTE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            sh       <= FLAG_BYTE;
            bitcnt   <= '0;
            ones     <= '0;
            cur_last <= 1'b0;
            fcs_hi   <= '0;
            tx_bit   <= 1'b0;
            underrun <= 1'b0;
        end else if (flush_evt) begin
            state    <= ST_ABORT;
            sh       <= ABORT_BYTE;
            bitcnt   <= '0;
            ones     <= '0;
            cur_last <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= urun_n;
            if (bit_en) begin
                tx_bit <= raw_bit ^ ctrl.line_inv;
            end
            if (stuff_now) begin
                ones <= '0;
            end else if (shift_now) begin
                ones     <= ones_n;
                bitcnt   <= bitcnt + 3'd1;
                state    <= state_n;
                sh       <= sh_n;
                cur_last <= cur_last_n;
                fcs_hi   <= fcs_hi_n;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_last,
    output logic       fifo_full,
    output logic       fifo_empty,
    output logic       overflow,
    input  logic       ctl_crc_off,
    input  logic       ctl_crc_inv,
    input  logic       ctl_stuff_off,
    input  logic       ctl_fill_idle,
    input  logic       ctl_line_inv,
    input  logic       ctl_flush,
    input  logic       bit_en,
    output logic       tx_bit,
    output logic       underrun
);

    localparam int QW = $bits(q_word_t);

    tx_ctrl_t         ctrl;
    q_word_t          wr_word, head;
    logic [QW-1:0]    head_raw;
    logic [CW-1:0]    fifo_count;
    logic [FCS_W-1:0] fcs_nx;
    logic             flush_q, flush_evt, pop, fcs_init, fcs_en, fcs_bit;

    always_comb begin
        ctrl.crc_off   = ctl_crc_off;
        ctrl.crc_inv   = ctl_crc_inv;
        ctrl.stuff_off = ctl_stuff_off;
        ctrl.fill_idle = ctl_fill_idle;
        ctrl.line_inv  = ctl_line_inv;
        wr_word.last   = wr_last;
        wr_word.data   = wr_data;
        head           = q_word_t'(head_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= ctl_flush;
    end
    assign flush_evt = ctl_flush && !flush_q;

    hdlc_tx_fifo #(.DEPTH(DEPTH), .W(QW)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_evt),
        .wr_en    (wr_en),
        .wr_data  (wr_word),
        .rd_en    (pop),
        .rd_data  (head_raw),
        .count    (fifo_count),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .overflow (overflow)
    );

    hdlc_tx_fcs u_fcs (
        .clk    (clk),
        .rst    (rst),
        .init   (fcs_init),
        .en     (fcs_en),
        .bit_in (fcs_bit),
        .fcs_nx (fcs_nx)
    );

    hdlc_tx_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .flush_evt  (flush_evt),
        .ctrl       (ctrl),
        .head       (head),
        .fifo_count (fifo_count),
        .fcs_nx     (fcs_nx),
        .pop        (pop),
        .fcs_init   (fcs_init),
        .fcs_en     (fcs_en),
        .fcs_bit    (fcs_bit),
        .tx_bit     (tx_bit),
        .underrun   (underrun)
    );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic fifo_full,
    input logic fifo_empty,
    input logic overflow,
    input logic ctl_flush,
    input logic bit_en,
    input logic tx_bit,
    input logic underrun
);

    // R12: the queue cannot be full and empty at once
    a_r12_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R12: a drop report needs a write against a full queue
    a_r12_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(wr_en && fifo_full));

    // R9: a flush edge leaves the queue empty one cycle later
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_flush) |=> fifo_empty);

    // R8: the line bit only moves on a strobe
    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));

    // R11: the underrun report lasts a single cycle
    a_r11_underrun_single: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .overflow   (overflow),
    .ctl_flush  (ctl_flush),
    .bit_en     (bit_en),
    .tx_bit     (tx_bit),
    .underrun   (underrun)
);

// File: tb/hdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_framer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_last = 1'b0;
    logic [7:0] wr_data = '0;
    logic       c_crc_off = 1'b0, c_crc_inv = 1'b0, c_stuff_off = 1'b0;
    logic       c_fill_idle = 1'b0, c_line_inv = 1'b0, c_flush = 1'b0;
    logic       bit_en = 1'b0;
    logic       fifo_full, fifo_empty, overflow, tx_bit, underrun;

    int checks = 0, fails = 0;
    int dens = 0, cap_n = 0, urun_cnt = 0, ovf_cnt = 0, sones = 0, exp_n = 0;
    logic       cap  [0:16383];
    logic       expb [0:1023];
    logic [7:0] pay  [0:15];

    always #5 clk = ~clk;

    hdlc_tx_framer u_hdlc_tx_framer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow),
        .ctl_crc_off(c_crc_off), .ctl_crc_inv(c_crc_inv), .ctl_stuff_off(c_stuff_off),
        .ctl_fill_idle(c_fill_idle), .ctl_line_inv(c_line_inv), .ctl_flush(c_flush),
        .bit_en(bit_en), .tx_bit(tx_bit), .underrun(underrun)
    );

    // monitor: captures the bit moved by the strobe of the previous edge
    always @(negedge clk) begin
        if (bit_en && cap_n < 16384) begin
            cap[cap_n] = tx_bit;
            cap_n++;
        end
        if (underrun) urun_cnt++;
        if (overflow) ovf_cnt++;
        bit_en <= ($urandom_range(99) < dens);
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_bits(input int k);
        int t;
        t = cap_n + k;
        while (cap_n < t) step();
    endtask

    function automatic logic [15:0] ref_fcs(input int n);
        logic [15:0] c;
        logic fb;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ pay[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic push_raw(input logic [7:0] v);
        for (int k = 0; k < 8; k++) begin
            expb[exp_n] = v[k];
            exp_n++;
        end
    endtask

    task automatic push_body(input logic [7:0] v, input logic nostuff);
        for (int k = 0; k < 8; k++) begin
            expb[exp_n] = v[k];
            exp_n++;
            sones = v[k] ? sones + 1 : 0;
            if (!nostuff && sones == 5) begin
                expb[exp_n] = 1'b0;
                exp_n++;
                sones = 0;
            end
        end
    endtask

    task automatic build(input int n, input logic coff, input logic cinv,
                         input logic soff, input logic [7:0] tail);
        logic [15:0] c;
        exp_n = 0;
        sones = 0;
        push_raw(8'h7E);
        for (int i = 0; i < n; i++) push_body(pay[i], soff);
        if (!coff) begin
            c = ref_fcs(n);
            if (!cinv) c = ~c;
            push_body(c[7:0], soff);
            push_body(c[15:8], soff);
        end
        push_raw(tail);
    endtask

    function automatic int find_exp(input int from, input logic inv);
        bit ok;
        for (int s = from; s + exp_n <= cap_n; s++) begin
            ok = 1'b1;
            for (int i = 0; i < exp_n; i++) begin
                if ((cap[s+i] ^ inv) !== expb[i]) ok = 1'b0;
            end
            if (ok) return s;
        end
        return -1;
    endfunction

    function automatic bit flag_fill_ok(input int from, input int len, input logic inv);
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(cap[from+i] ^ inv);
        if (ones != 6) return 1'b0;
        for (int i = from + 8; i < from + len; i++) begin
            if (cap[i] !== cap[i-8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic write_byte(input logic [7:0] d, input logic last);
        wr_en   = 1'b1;
        wr_data = d;
        wr_last = last;
        step();
        wr_en   = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic run_pkt(input int n, input logic coff, input logic cinv,
                           input logic soff, input logic linv, input logic fidle,
                           input string req);
        int mark, pos;
        c_crc_off = coff; c_crc_inv = cinv; c_stuff_off = soff;
        c_line_inv = linv; c_fill_idle = fidle;
        step();
        mark = cap_n;
        build(n, coff, cinv, soff, 8'h7E);
        for (int i = 0; i < n; i++) write_byte(pay[i], i == n - 1);
        wait_bits(exp_n + 48);
        pos = find_exp(mark, linv);
        check(pos >= 0, req, "framed packet on line", pos, mark);
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom_range(255));
    endtask

    task automatic quiet_flush();
        dens = 0;
        step(); step(); step();
        c_flush = 1'b1;
        step();
        c_flush = 1'b0;
    endtask

    task automatic check_abort_then_fill(input string req);
        int mark;
        logic [15:0] got;
        mark = cap_n;
        dens = 70;
        wait_bits(24);
        for (int i = 0; i < 16; i++) got[i] = cap[mark+i];
        check(got == 16'h7EFE, req, "abort byte then flag", int'(got), 32'h7EFE);
    endtask

    initial begin
        int mark, u0, o0;
        logic held;
        logic [7:0] first;
        void'($urandom(32'd20240611));
        repeat (5) step();
        rst = 1'b0;
        cap_n = 0;
        dens = 60;
        // R1: reset state
        check(fifo_empty === 1'b1 && fifo_full === 1'b0, "R1", "queue empty after reset",
              int'({fifo_full, fifo_empty}), 1);
        check(underrun === 1'b0 && overflow === 1'b0, "R1", "pulses low after reset",
              int'({underrun, overflow}), 0);
        wait_bits(72);
        for (int i = 0; i < 8; i++) first[i] = cap[i];
        check(first == 8'h7E, "R1", "first byte is a flag", int'(first), 32'h7E);
        // R2: flag fill is 8-periodic with six ones per byte
        check(flag_fill_ok(0, 64, 1'b0), "R2", "flag fill pattern", 0, 1);
        // R2: all-ones fill
        c_fill_idle = 1'b1;
        wait_bits(16);
        mark = cap_n;
        wait_bits(32);
        held = 1'b1;
        for (int i = mark; i < mark + 32; i++) if (cap[i] !== 1'b1) held = 1'b0;
        check(held, "R2", "FFh fill all ones", int'(held), 1);
        // R8: inverted all-ones fill is all zeros
        c_line_inv = 1'b1;
        wait_bits(4);
        mark = cap_n;
        wait_bits(32);
        held = 1'b1;
        for (int i = mark; i < mark + 32; i++) if (cap[i] !== 1'b0) held = 1'b0;
        check(held, "R8", "inverted fill all zeros", int'(held), 1);
        c_line_inv = 1'b0;
        c_fill_idle = 1'b0;
        wait_bits(24);
        // R8: no strobe, no movement, even across a line-inversion change
        dens = 0;
        step(); step();
        held = tx_bit;
        c_line_inv = 1'b1;
        repeat (20) step();
        check(tx_bit === held, "R8", "tx_bit holds without strobe", int'(tx_bit), int'(held));
        c_line_inv = 1'b0;
        dens = 70;
        wait_bits(16);

        // R3: plain packets
        fill_random(4);  run_pkt(4, 0, 0, 0, 0, 0, "R3");
        pay[0] = 8'hA5;  run_pkt(1, 0, 0, 0, 0, 0, "R3 single last byte R10");
        // R4: inverted check sequence
        fill_random(5);  run_pkt(5, 0, 1, 0, 0, 0, "R4");
        // R5: check sequence dropped, inversion ignored
        fill_random(3);  run_pkt(3, 1, 0, 0, 0, 0, "R5");
        fill_random(3);  run_pkt(3, 1, 1, 0, 0, 0, "R5 inv ignored");
        // R6: dense ones force stuffing, including before the closing flag
        for (int i = 0; i < 4; i++) pay[i] = 8'hFF;
        run_pkt(4, 0, 0, 0, 0, 0, "R6 all ones");
        pay[0] = 8'h7E; pay[1] = 8'h1F; pay[2] = 8'hF8;
        run_pkt(3, 1, 0, 0, 0, 0, "R6 run ends at close");
        // R7: no insertion
        pay[0] = 8'hFF; pay[1] = 8'h3F; pay[2] = 8'hFC;
        run_pkt(3, 0, 0, 1, 0, 0, "R7");
        // R8: whole stream inverted
        fill_random(6);  run_pkt(6, 0, 0, 0, 1, 0, "R8 line inv");

        // R11: queue runs dry mid-packet
        u0 = urun_cnt;
        pay[0] = 8'($urandom_range(255)); pay[1] = 8'hF8;
        c_line_inv = 0; c_crc_off = 0; c_stuff_off = 0; c_fill_idle = 0;
        step();
        mark = cap_n;
        build(2, 1'b1, 1'b0, 1'b0, 8'hFE);
        write_byte(pay[0], 1'b0);
        write_byte(pay[1], 1'b0);
        wait_bits(exp_n + 48);
        check(find_exp(mark, 1'b0) >= 0, "R11", "abort after starved payload",
              find_exp(mark, 1'b0), mark);
        check(urun_cnt - u0 == 1, "R11", "one underrun pulse", urun_cnt - u0, 1);
        check(flag_fill_ok(cap_n - 32, 32, 1'b0), "R11", "fill after abort", 0, 1);

        // R12: fill the queue with no strobes, then overflow it
        dens = 0;
        step(); step(); step();
        o0 = ovf_cnt;
        for (int i = 0; i < 16; i++) write_byte(8'(i), 1'b0);
        check(fifo_full === 1'b1, "R12", "full after 16 writes", int'(fifo_full), 1);
        write_byte(8'h55, 1'b1);
        step();
        check(ovf_cnt - o0 == 1, "R12", "overflow pulse on dropped write", ovf_cnt - o0, 1);
        check(fifo_full === 1'b1, "R12", "still full after drop", int'(fifo_full), 1);
        // R9: flush from a full queue
        c_flush = 1'b1;
        step();
        c_flush = 1'b0;
        check(fifo_empty === 1'b1, "R9", "empty after flush", int'(fifo_empty), 1);
        check_abort_then_fill("R9");

        // R9: flush in the middle of a packet
        fill_random(10);
        step();
        for (int i = 0; i < 10; i++) write_byte(pay[i], i == 9);
        wait_bits(40);
        quiet_flush();
        check(fifo_empty === 1'b1, "R9", "empty after mid-packet flush", int'(fifo_empty), 1);
        check_abort_then_fill("R9 mid-packet");

        // R10: one unterminated byte does not start a packet
        wait_bits(8);
        mark = cap_n;
        pay[0] = 8'h3C; pay[1] = 8'hC3;
        build(2, 1'b0, 1'b0, 1'b0, 8'h7E);
        write_byte(pay[0], 1'b0);
        wait_bits(64);
        check(fifo_empty === 1'b0, "R10", "single byte left queued", int'(fifo_empty), 0);
        check(flag_fill_ok(cap_n - 40, 40, 1'b0), "R10", "line still in fill", 0, 1);
        write_byte(pay[1], 1'b1);
        wait_bits(exp_n + 48);
        check(find_exp(mark, 1'b0) >= 0, "R10", "packet after second byte",
              find_exp(mark, 1'b0), mark);

        // R3 R4 R5 R6 R7 R8: random packets with random controls
        for (int it = 0; it < 16; it++) begin
            int n;
            n = 1 + $urandom_range(11);
            fill_random(n);
            dens = 40 + $urandom_range(60);
            run_pkt(n, 1'($urandom_range(1)), 1'($urandom_range(1)),
                    1'($urandom_range(1)), 1'($urandom_range(1)),
                    1'($urandom_range(1)), "R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule